// File: doc/BRIEF.md
# I2C FIFO and Interrupt Status Unit

This unit is the register-side companion of an I2C master bus engine. Software writes byte commands into a 16-entry transmit queue and reads received bytes out of a 16-entry receive queue through a simple word-addressed register port. The engine pops commands and pushes received bytes through dedicated FIFO ports. Each transmit entry holds 8 data bits, with bit 8 requesting a start condition and bit 9 requesting a stop condition.

The unit turns engine events and FIFO conditions into eight interrupt sources. They are latched in a write-1-to-clear status register, masked by an enable register and gated by a global enable bit to form one interrupt line. A control register enables the engine and can hold the transmit queue in reset. A key write to a soft-reset register returns the whole unit to its reset state. Bus protocol timing is not part of this block.

Register word addresses: 0 control, 1 status, 2 transmit data (write), 3 receive data (read), 4 transmit level, 5 receive level, 6 receive watermark, 7 global enable, 8 interrupt status, 9 interrupt enable, 10 soft reset.

Top module: `i2c_fifo_irq_unit`

## Requirements
- R1: A write to address 2 while the transmit queue holds fewer than 16 entries appends reg_wdata[9:0]. A write to a full queue is ignored. cmd_valid is high when the queue is not empty, cmd_data shows the oldest entry, and cmd_pop removes it, so entries leave in the order they were written.
- R2: A read of address 3 returns the oldest received byte in bits 7:0 and removes it. A read while the receive queue is empty returns 0 and changes nothing. rx_push on a full receive queue is ignored.
- R3: Address 4 and address 5 read the transmit and receive entry counts minus one, and read 0 when the queue is empty.
- R4: The status register at address 1 reads bus_busy in bit 2, transmit full in bit 4, receive full in bit 5, receive empty in bit 6 and transmit empty in bit 7. All other bits read 0.
- R5: Interrupt status bit 3 is set in every cycle in which the receive count is greater than the zero-based watermark held at address 6, bits 3:0.
- R6: Interrupt status bits 2 (transmit queue empty), 4 (bus not busy) and 7 (transmit count at most 8) are set only on the rising edge of their condition. A condition that stays true does not set the bit again after it is cleared.
- R7: Status bit 0 is set by an arb_lost pulse and bit 1 by a tx_error pulse. Bit 5 follows slave_addressed high, and bit 6 follows slave_addressed low, each for as long as that level holds.
- R8: Writing 1s to address 8 clears those status bits in the same edge. A source that is active in that cycle keeps its bit set.
- R9: irq is high exactly when bit 31 of the global enable register (address 7) is 1 and the interrupt status AND the enable register (address 9, bits 7:0) is non-zero.
- R10: Control bit 0 (address 0) drives core_en. While control bit 1 is 1, the transmit queue is empty and writes to address 2 are ignored.
- R11: Writing exactly 0x0000000A to address 10 clears every register and both queues in that edge. Any other value written there has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops receive data at address 3) |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| core_en | output | 1 | Engine enable (control bit 0) |
| cmd_valid | output | 1 | Transmit queue holds a command |
| cmd_data | output | 10 | Oldest command: data, start flag bit 8, stop flag bit 9 |
| cmd_pop | input | 1 | Engine takes the oldest command |
| rx_push | input | 1 | Engine delivers a received byte |
| rx_data | input | 8 | Received byte |
| bus_busy | input | 1 | Bus busy level from the engine |
| arb_lost | input | 1 | Arbitration lost pulse |
| tx_error | input | 1 | Transmit error pulse |
| slave_addressed | input | 1 | Addressed-as-slave level |
| irq | output | 1 | Combined interrupt line |

## Verification
The edge-set sources are the hardest to reach, because each needs its condition to go false and then true again after reset. The transmit half-empty edge needs the queue filled past 8 entries and then drained by one. The directed stimulus writes nine commands, clears the status register, and pops single entries while it reads the status after each step. It also checks that a condition that stays true does not set its bit again after a clear. The level sources are checked the opposite way: a clear written while the level holds must leave the bit set.

// File: rtl/i2c_fu_pkg.sv
package i2c_fu_pkg;
  localparam int ADDR_W = 4;
  localparam logic [ADDR_W-1:0] A_CTRL  = 4'd0;
  localparam logic [ADDR_W-1:0] A_STAT  = 4'd1;
  localparam logic [ADDR_W-1:0] A_TXD   = 4'd2;
  localparam logic [ADDR_W-1:0] A_RXD   = 4'd3;
  localparam logic [ADDR_W-1:0] A_TXLVL = 4'd4;
  localparam logic [ADDR_W-1:0] A_RXLVL = 4'd5;
  localparam logic [ADDR_W-1:0] A_RXWM  = 4'd6;
  localparam logic [ADDR_W-1:0] A_GIE   = 4'd7;
  localparam logic [ADDR_W-1:0] A_ISR   = 4'd8;
  localparam logic [ADDR_W-1:0] A_IER   = 4'd9;
  localparam logic [ADDR_W-1:0] A_SRST  = 4'd10;

  localparam logic [31:0] SRST_KEY = 32'h0000_000A;
  localparam int NSRC = 8;
  // interrupt source bit positions
  localparam int S_ARB = 0, S_TXERR = 1, S_TXEMPTY = 2, S_RXWM = 3;
  localparam int S_IDLE = 4, S_AAS = 5, S_NAAS = 6, S_TXHALF = 7;
  // sources latched on a rising edge of their condition
  localparam logic [NSRC-1:0] EDGE_MASK = 8'b1001_0100;

  // zero-based occupancy: count minus one, floored at zero
  function automatic logic [31:0] zb_level(input logic [31:0] cnt);
    return (cnt == 32'd0) ? 32'd0 : cnt - 32'd1;
  endfunction
endpackage

// File: rtl/i2c_fu_fifo.sv
module i2c_fu_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 16,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  dout,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic          do_push, do_pop;

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem[rp];

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; count <= '0;
    end else if (flush) begin
      wp <= '0; rp <= '0; count <= '0;
    end else begin
      if (do_push) wp <= bump(wp);
      if (do_pop)  rp <= bump(rp);
      case ({do_push, do_pop})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (do_push && !flush) mem[wp] <= din;
  end
endmodule

// File: rtl/i2c_fu_irq.sv
module i2c_fu_irq
  import i2c_fu_pkg::*;
#(
  parameter int N = NSRC,
  parameter logic [N-1:0] EDGE = EDGE_MASK
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         srst,
  input  logic [N-1:0] cond,
  input  logic         isr_we,
  input  logic         ier_we,
  input  logic         gie_we,
  input  logic [31:0]  wdata,
  output logic [N-1:0] isr,
  output logic [N-1:0] ier,
  output logic         gie,
  output logic [N-1:0] set_vec,
  output logic [N-1:0] clr_vec,
  output logic         irq
);
  for (genvar i = 0; i < N; i++) begin : g_src
    if (EDGE[i]) begin : g_edge
      logic prev;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    prev <= 1'b1;
        else if (srst) prev <= 1'b1;
        else           prev <= cond[i];
      end
      assign set_vec[i] = cond[i] && !prev;
    end else begin : g_level
      assign set_vec[i] = cond[i];
    end
  end

  assign clr_vec = isr_we ? wdata[N-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      isr <= '0; ier <= '0; gie <= 1'b0;
    end else if (srst) begin
      isr <= '0; ier <= '0; gie <= 1'b0;
    end else begin
      isr <= (isr & ~clr_vec) | set_vec;
      if (ier_we) ier <= wdata[N-1:0];
      if (gie_we) gie <= wdata[31];
    end
  end

  assign irq = gie && |(isr & ier);
endmodule

// File: rtl/i2c_fifo_irq_unit.sv
module i2c_fifo_irq_unit
  import i2c_fu_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  localparam int CMDW = DW + 2,
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int TW   = $clog2(DEPTH)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reg_wr,
  input  logic            reg_rd,
  input  logic [3:0]      reg_addr,
  input  logic [31:0]     reg_wdata,
  output logic [31:0]     reg_rdata,
  output logic            core_en,
  output logic            cmd_valid,
  output logic [CMDW-1:0] cmd_data,
  input  logic            cmd_pop,
  input  logic            rx_push,
  input  logic [DW-1:0]   rx_data,
  input  logic            bus_busy,
  input  logic            arb_lost,
  input  logic            tx_error,
  input  logic            slave_addressed,
  output logic            irq
);
  // named internal events, observed by the bound checker
  logic            srst;
  logic            tx_wr_req, rx_rd_req;
  logic [1:0]      ctrl;
  logic [TW-1:0]   rx_wm;
  logic [CW-1:0]   tx_cnt, rx_cnt;
  logic            tx_full, tx_empty, rx_full, rx_empty;
  logic [DW-1:0]   rx_head;
  logic [NSRC-1:0] cond, isr, ier, isr_set, isr_clr;
  logic            gie;

  assign srst      = reg_wr && (reg_addr == A_SRST) && (reg_wdata == SRST_KEY);
  assign tx_wr_req = reg_wr && (reg_addr == A_TXD) && !ctrl[1];
  assign rx_rd_req = reg_rd && (reg_addr == A_RXD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl <= '0; rx_wm <= '0;
    end else if (srst) begin
      ctrl <= '0; rx_wm <= '0;
    end else if (reg_wr) begin
      if (reg_addr == A_CTRL) ctrl  <= reg_wdata[1:0];
      if (reg_addr == A_RXWM) rx_wm <= reg_wdata[TW-1:0];
    end
  end

  assign core_en   = ctrl[0];
  assign cmd_valid = !tx_empty;

  i2c_fu_fifo #(.W(CMDW), .DEPTH(DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_n), .flush(srst || ctrl[1]),
    .push(tx_wr_req), .din(reg_wdata[CMDW-1:0]), .pop(cmd_pop),
    .dout(cmd_data), .count(tx_cnt), .full(tx_full), .empty(tx_empty)
  );

  i2c_fu_fifo #(.W(DW), .DEPTH(DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_n), .flush(srst),
    .push(rx_push), .din(rx_data), .pop(rx_rd_req),
    .dout(rx_head), .count(rx_cnt), .full(rx_full), .empty(rx_empty)
  );

  always_comb begin
    cond            = '0;
    cond[S_ARB]     = arb_lost;
    cond[S_TXERR]   = tx_error;
    cond[S_TXEMPTY] = tx_empty;
    cond[S_RXWM]    = rx_cnt > CW'(rx_wm);
    cond[S_IDLE]    = !bus_busy;
    cond[S_AAS]     = slave_addressed;
    cond[S_NAAS]    = !slave_addressed;
    cond[S_TXHALF]  = tx_cnt <= CW'(DEPTH / 2);
  end

  i2c_fu_irq #(.N(NSRC), .EDGE(EDGE_MASK)) u_irq (
    .clk(clk), .rst_n(rst_n), .srst(srst), .cond(cond),
    .isr_we(reg_wr && reg_addr == A_ISR && !srst),
    .ier_we(reg_wr && reg_addr == A_IER),
    .gie_we(reg_wr && reg_addr == A_GIE),
    .wdata(reg_wdata), .isr(isr), .ier(ier), .gie(gie),
    .set_vec(isr_set), .clr_vec(isr_clr), .irq(irq)
  );

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_CTRL:  reg_rdata[1:0] = ctrl;
      A_STAT:  begin
        reg_rdata[2] = bus_busy;
        reg_rdata[4] = tx_full;
        reg_rdata[5] = rx_full;
        reg_rdata[6] = rx_empty;
        reg_rdata[7] = tx_empty;
      end
      A_RXD:   if (!rx_empty) reg_rdata[DW-1:0] = rx_head;
      A_TXLVL: reg_rdata = zb_level(32'(tx_cnt));
      A_RXLVL: reg_rdata = zb_level(32'(rx_cnt));
      A_RXWM:  reg_rdata[TW-1:0] = rx_wm;
      A_GIE:   reg_rdata[31] = gie;
      A_ISR:   reg_rdata[NSRC-1:0] = isr;
      A_IER:   reg_rdata[NSRC-1:0] = ier;
      default: reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/i2c_fu_chk.sv
module i2c_fu_chk #(
  parameter int DEPTH = 16,
  parameter int CW    = 5,
  parameter int N     = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          srst,
  input logic          rx_push,
  input logic          rx_rd_req,
  input logic          rx_full,
  input logic [CW-1:0] tx_cnt,
  input logic [CW-1:0] rx_cnt,
  input logic [1:0]    ctrl,
  input logic [N-1:0]  isr,
  input logic [N-1:0]  ier,
  input logic [N-1:0]  isr_set,
  input logic [N-1:0]  isr_clr,
  input logic          gie,
  input logic          irq
);
  // R1
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_cnt <= CW'(DEPTH)) && (rx_cnt <= CW'(DEPTH)));
  // R2
  full_push_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_full && rx_push && !rx_rd_req && !srst) |=> $stable(rx_cnt));
  // R2
  empty_pop_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((rx_cnt == '0) && rx_rd_req && !rx_push && !srst) |=> (rx_cnt == '0));
  // R8
  w1c_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(isr_clr & ~isr_set)) |=> ((isr & $past(isr_clr & ~isr_set)) == '0));
  // R9
  gie_gates_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !gie |-> !irq);
  // R11
  soft_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    srst |=> (tx_cnt == '0 && rx_cnt == '0 && ier == '0 && !gie && ctrl == '0));
endmodule

bind i2c_fifo_irq_unit i2c_fu_chk #(.DEPTH(DEPTH), .CW(CW), .N(i2c_fu_pkg::NSRC)) u_chk (
  .clk(clk), .rst_n(rst_n), .srst(srst), .rx_push(rx_push), .rx_rd_req(rx_rd_req),
  .rx_full(rx_full), .tx_cnt(tx_cnt), .rx_cnt(rx_cnt), .ctrl(ctrl), .isr(isr),
  .ier(ier), .isr_set(isr_set), .isr_clr(isr_clr), .gie(gie), .irq(irq)
);

// File: tb/i2c_fifo_irq_unit_bench.sv
module i2c_fifo_irq_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 0, reg_rd = 0;
  logic [3:0]  reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic        core_en, cmd_valid, cmd_pop = 0, rx_push = 0;
  logic [9:0]  cmd_data;
  logic [7:0]  rx_data = 0;
  logic        bus_busy = 0, arb_lost = 0, tx_error = 0, slave_addressed = 0;
  logic        irq;
  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  i2c_fifo_irq_unit u_i2c_fifo_irq_unit (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .core_en(core_en),
    .cmd_valid(cmd_valid), .cmd_data(cmd_data), .cmd_pop(cmd_pop),
    .rx_push(rx_push), .rx_data(rx_data), .bus_busy(bus_busy), .arb_lost(arb_lost),
    .tx_error(tx_error), .slave_addressed(slave_addressed), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk); reg_rd = 1; reg_addr = a; #1 d = reg_rdata;
    @(negedge clk); reg_rd = 0;
  endtask

  task automatic expect_reg(input string req, input logic [3:0] a, input logic [31:0] e);
    logic [31:0] v;
    rd(a, v); check(req, v, e);
  endtask

  task automatic eng_pop(output logic [9:0] d);
    @(negedge clk); d = cmd_data; cmd_pop = 1;
    @(negedge clk); cmd_pop = 0;
  endtask

  task automatic eng_push(input logic [7:0] b);
    @(negedge clk); rx_push = 1; rx_data = b;
    @(negedge clk); rx_push = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    check("R4 status at reset", 0, 0);
    expect_reg("R4 status at reset", 4'd1, 32'h0000_00C0);
    expect_reg("R10 ctrl at reset", 4'd0, 32'h0);
    expect_reg("R3 tx level empty", 4'd4, 32'h0);
    check("R9 irq at reset", {31'd0, irq}, 32'h0);
  endtask

  task automatic t_txq;
    logic [9:0] d;
    wr(4'd10, 32'hA);
    for (int i = 0; i < 17; i++) wr(4'd2, 32'h100 + 32'(i));
    expect_reg("R3 tx level full", 4'd4, 32'd15);
    expect_reg("R4 tx full flag", 4'd1, 32'h0000_0050);
    for (int i = 0; i < 16; i++) begin
      eng_pop(d);
      check("R1 tx order", {22'd0, d}, 32'h100 + 32'(i));
    end
    check("R1 tx drained", {31'd0, cmd_valid}, 32'h0);
  endtask

  task automatic t_rxq;
    logic [31:0] v;
    wr(4'd10, 32'hA);
    for (int i = 0; i < 3; i++) eng_push(8'h30 + 8'(i));
    expect_reg("R3 rx level", 4'd5, 32'd2);
    for (int i = 0; i < 3; i++) begin
      rd(4'd3, v);
      check("R2 rx order", v, 32'h30 + 32'(i));
    end
    rd(4'd3, v);
    check("R2 empty read", v, 32'h0);
    expect_reg("R2 empty read no change", 4'd5, 32'h0);
    for (int i = 0; i < 17; i++) eng_push(8'(i + 1));
    expect_reg("R2 rx full level", 4'd5, 32'd15);
    expect_reg("R4 rx full flag", 4'd1, 32'h0000_00A0);
    rd(4'd3, v);
    check("R2 full push dropped", v, 32'h1);
    for (int i = 0; i < 14; i++) rd(4'd3, v);
    rd(4'd3, v);
    check("R2 last kept entry", v, 32'd16);
  endtask

  task automatic t_watermark;
    wr(4'd10, 32'hA);
    wr(4'd6, 32'd2);
    eng_push(8'h11); eng_push(8'h22); idle(2);
    expect_reg("R5 below watermark", 4'd8, 32'h40);
    eng_push(8'h33); idle(2);
    expect_reg("R5 watermark reached", 4'd8, 32'h48);
    wr(4'd8, 32'h08); idle(1);
    expect_reg("R8 level source stays", 4'd8, 32'h48);
    begin logic [31:0] v; rd(4'd3, v); end
    wr(4'd8, 32'h08); idle(1);
    expect_reg("R5 below after pop", 4'd8, 32'h40);
  endtask

  task automatic t_edges;
    logic [9:0] d;
    wr(4'd10, 32'hA);
    for (int i = 0; i < 9; i++) wr(4'd2, 32'(i));
    wr(4'd8, 32'hFF); idle(2);
    expect_reg("R6 no edge yet", 4'd8, 32'h40);
    eng_pop(d); idle(2);
    expect_reg("R6 half-empty edge", 4'd8, 32'hC0);
    wr(4'd8, 32'h80); idle(2);
    expect_reg("R6 held half no reset", 4'd8, 32'h40);
    for (int i = 0; i < 8; i++) eng_pop(d);
    idle(2);
    expect_reg("R6 empty edge", 4'd8, 32'h44);
    bus_busy = 1; idle(3);
    expect_reg("R4 busy flag", 4'd1, 32'h0000_00C4);
    bus_busy = 0; idle(3);
    expect_reg("R6 bus idle edge", 4'd8, 32'h54);
    @(negedge clk); arb_lost = 1; @(negedge clk); arb_lost = 0;
    @(negedge clk); tx_error = 1; @(negedge clk); tx_error = 0;
    idle(1);
    expect_reg("R7 pulse sources", 4'd8, 32'h57);
    wr(4'd8, 32'h97); idle(1);
    expect_reg("R8 w1c clear", 4'd8, 32'h40);
    slave_addressed = 1; idle(2);
    expect_reg("R7 addressed level", 4'd8, 32'h60);
    wr(4'd8, 32'h40); idle(1);
    expect_reg("R7 not-addressed cleared", 4'd8, 32'h20);
    wr(4'd8, 32'h20); idle(1);
    expect_reg("R8 active level keeps bit", 4'd8, 32'h20);
    slave_addressed = 0; idle(2);
  endtask

  task automatic t_irq;
    wr(4'd10, 32'hA);
    wr(4'd8, 32'hFF);
    wr(4'd9, 32'h01);
    @(negedge clk); arb_lost = 1; @(negedge clk); arb_lost = 0; idle(1);
    check("R9 gie off masks irq", {31'd0, irq}, 32'h0);
    wr(4'd7, 32'h8000_0000); #1;
    check("R9 irq asserted", {31'd0, irq}, 32'h1);
    expect_reg("R9 gie readback", 4'd7, 32'h8000_0000);
    wr(4'd9, 32'h02); #1;
    check("R9 enable masks irq", {31'd0, irq}, 32'h0);
    wr(4'd9, 32'h01);
    wr(4'd8, 32'h01); #1;
    check("R9 irq after clear", {31'd0, irq}, 32'h0);
    wr(4'd7, 32'h7FFF_FFFF);
    expect_reg("R9 gie bit31 only", 4'd7, 32'h0);
  endtask

  task automatic t_ctrl;
    wr(4'd10, 32'hA);
    wr(4'd0, 32'h3); #1;
    check("R10 core_en", {31'd0, core_en}, 32'h1);
    wr(4'd2, 32'h55); idle(1);
    check("R10 tx held in reset", {31'd0, cmd_valid}, 32'h0);
    wr(4'd0, 32'h1);
    wr(4'd2, 32'h66); wr(4'd2, 32'h77); #1;
    check("R10 tx accepted", {22'd0, cmd_data}, 32'h66);
    wr(4'd0, 32'h3);
    expect_reg("R10 tx flushed", 4'd1, 32'h0000_00C0);
  endtask

  task automatic t_srst;
    wr(4'd10, 32'hA);
    wr(4'd9, 32'h5A); wr(4'd0, 32'h1); wr(4'd2, 32'h12);
    wr(4'd10, 32'h5);
    expect_reg("R11 wrong key ignored", 4'd9, 32'h5A);
    wr(4'd10, 32'hA);
    expect_reg("R11 ier cleared", 4'd9, 32'h0);
    expect_reg("R11 ctrl cleared", 4'd0, 32'h0);
    check("R11 tx queue cleared", {31'd0, cmd_valid}, 32'h0);
  endtask

  initial begin
    fork
      begin
        idle(3); rst_n = 1; idle(2);
        t_reset; t_txq; t_rxq; t_watermark; t_edges; t_irq; t_ctrl; t_srst;
      end
      begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule